// File: doc/BRIEF.md
# Power Mode Sequencer with Event Timers and Management Interrupt

This block governs the power state of a system. It watches two classes of activity. Wake-class events keep the system awake. Notice-class events are only recorded. Three countdown timers run at the same time: an idle timer, a peripheral timer and a general-purpose timer. Each time the idle timer runs out, the system steps down one power level. The levels run from normal through doze and sleep to suspend, and a separate conserve level can only be chosen by software. The current level drives a clock-throttle gate. In suspend it also drives a clock-stop request, which is released only after a wake event plus a fixed settling delay.

Timer expiries, notice-class events and six external event pins set sticky status bits. Software clears a status bit by writing a 1 to it. A system management interrupt is raised whenever any status bit is set whose enable bit is also set. Software configures the block through a simple write-only port: a write strobe, a 3-bit address and a data word.

Top module: `pmModeCtrl`

## Requirements
- R1: After reset the mode output is 0 (normal), the clock gate, clock-stop request and interrupt are 0, every status bit is 0, all three timers are disabled and all interrupt enables are 0.
- R2: Mode codes are normal=0, doze=1, sleep=2, suspend=3 and conserve=4. Writing a value R to address 0 loads the idle timer and sets its reload value; 0 disables the timer. The timer expires R cycles after it is loaded and then reloads itself. Each expiry outside conserve moves the mode one step down the order 0, 1, 2, 3, and the mode stays at 3 once it is there.
- R3: Any bit of the wake-class input `activityA` reloads the idle timer and returns the mode to normal on the next clock edge. This does not apply in conserve mode.
- R4: In normal mode `clkGate` is 0. In sleep and suspend it is 1 on every cycle. In doze it is 1 on exactly D of every 8 consecutive cycles, where D is bits [2:0] of the control register at address 5.
- R5: `clkStopReq` rises on the same edge that the mode enters suspend. After the mode leaves suspend, it stays at 1 for WAKE_DLY more cycles and then falls.
- R6: Writing bit 3 of the control register to 1 enters conserve mode (4). Writing it to 0 returns the mode to normal. While in conserve, wake-class events and idle expiries leave the mode unchanged, and `clkGate` is 1 on CONSERVE_DUTY of every 8 cycles, whatever the value of D.
- R7: The status layout is as follows. Bits [5:0] are the external pins. Bits [6+NUM_B-1:6] are the notice-class events. Bit 6+NUM_B is the peripheral timer expiry, bit 7+NUM_B is the general-purpose timer expiry and bit 8+NUM_B is the idle timer expiry. Each bit stays set until a write to address 4 with a 1 in that bit position. Bits written with 0 are left unchanged, and a set in the same cycle as a clear wins.
- R8: `smiOut` is 1 exactly when some status bit is set whose bit in the enable register (address 3, same layout as the status) is also 1.
- R9: A high level on external pin k sets status bit k. Pin k raises the interrupt only when enable bit k is set.
- R10: Notice-class events (`activityB`) set their status bits and reload the peripheral timer, but never change the mode.
- R11: The peripheral timer (address 1) and the general-purpose timer (address 2) behave like the idle timer, with a load value and 0 meaning disabled. Each expiry sets that timer's status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| activityA | input | NUM_A | Wake-class activity pulses |
| activityB | input | NUM_B | Notice-class activity pulses |
| extEvent | input | 6 | External event pins, sampled as levels |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address (0 idle, 1 peripheral, 2 general, 3 enable, 4 clear, 5 control) |
| regWrData | input | DATA_W | Register write data |
| pwrMode | output | 3 | Current power mode code |
| clkGate | output | 1 | Clock throttle gate, 1 = suppress this cycle |
| clkStopReq | output | 1 | Clock-stop request |
| smiOut | output | 1 | System management interrupt |
| smiStatus | output | 9+NUM_B | Sticky status bits |

## Verification
The bench builds the block with two wake-class inputs, two notice-class inputs, 8-bit timers, a wake delay of 4 and a conserve duty of 3. With these short values, the bench can step a full idle descent from normal to suspend and check the saturation at suspend, and it can watch the clock-stop release edge cycle by cycle. It sweeps every doze duty from 0 to 7 and every one of the six external pins, both with and without its enable. It also counts the timer expiries to the exact cycle.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    MODE_NORMAL   = 3'd0,
    MODE_DOZE     = 3'd1,
    MODE_SLEEP    = 3'd2,
    MODE_SUSPEND  = 3'd3,
    MODE_CONSERVE = 3'd4
  } pmMode_e;

  localparam int NUM_EXT    = 6;
  localparam int NUM_TIMERS = 3;
  localparam int TMR_IDLE   = 0;
  localparam int TMR_PERI   = 1;
  localparam int TMR_GP     = 2;

  localparam logic [2:0] ADDR_IDLE = 3'd0;
  localparam logic [2:0] ADDR_PERI = 3'd1;
  localparam logic [2:0] ADDR_GP   = 3'd2;
  localparam logic [2:0] ADDR_MASK = 3'd3;
  localparam logic [2:0] ADDR_CLR  = 3'd4;
  localparam logic [2:0] ADDR_CTRL = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_TIMERS-1:0] loadTmr;
    logic                  wrMask;
    logic                  clrStatus;
  } pmStrobe_t;
endpackage

// File: rtl/pmTimer.sv
module pmTimer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               load,
  input  logic [TIMER_W-1:0] loadVal,
  input  logic [TIMER_W-1:0] reloadVal,
  output logic               expire
);
  logic [TIMER_W-1:0] cnt;

  assign expire = (cnt == TIMER_W'(1)) && !load;

  always_ff @(posedge clk) begin
    if (!rstN)                   cnt <= '0;
    else if (load)               cnt <= loadVal;
    else if (cnt == TIMER_W'(1)) cnt <= reloadVal;
    else if (cnt != '0)          cnt <= cnt - TIMER_W'(1);
  end
endmodule

// File: rtl/pmDatapath.sv
module pmDatapath
  import pm_pkg::*;
#(
  parameter int NUM_A   = 2,
  parameter int NUM_B   = 2,
  parameter int TIMER_W = 16,
  parameter int DATA_W  = 16,
  localparam int STAT_W = NUM_EXT + NUM_B + NUM_TIMERS
) (
  input  logic               clk,
  input  logic               rstN,
  input  pmStrobe_t          strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_A-1:0]   activityA,
  input  logic [NUM_B-1:0]   activityB,
  input  logic [NUM_EXT-1:0] extEvent,
  output logic               idleExpire,
  output logic [STAT_W-1:0]  status,
  output logic               smi
);
  logic [TIMER_W-1:0]    reloadReg [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] tmrLoad;
  logic [NUM_TIMERS-1:0] tmrExpire;
  logic [STAT_W-1:0]     maskReg;
  logic [STAT_W-1:0]     setVec;
  logic [STAT_W-1:0]     clrVec;

  // wake-class events reload the idle timer, notice-class the peripheral one
  assign tmrLoad[TMR_IDLE] = strobe.loadTmr[TMR_IDLE] | (|activityA);
  assign tmrLoad[TMR_PERI] = strobe.loadTmr[TMR_PERI] | (|activityB);
  assign tmrLoad[TMR_GP]   = strobe.loadTmr[TMR_GP];

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    logic [TIMER_W-1:0] loadVal;
    assign loadVal = strobe.loadTmr[t] ? wrData[TIMER_W-1:0] : reloadReg[t];

    always_ff @(posedge clk) begin
      if (!rstN)                  reloadReg[t] <= '0;
      else if (strobe.loadTmr[t]) reloadReg[t] <= wrData[TIMER_W-1:0];
    end

    pmTimer #(.TIMER_W(TIMER_W)) u_tmr (
      .clk      (clk),
      .rstN     (rstN),
      .load     (tmrLoad[t]),
      .loadVal  (loadVal),
      .reloadVal(reloadReg[t]),
      .expire   (tmrExpire[t])
    );
  end

  assign idleExpire = tmrExpire[TMR_IDLE];

  assign setVec = {tmrExpire[TMR_IDLE], tmrExpire[TMR_GP], tmrExpire[TMR_PERI],
                   activityB, extEvent};
  assign clrVec = strobe.clrStatus ? wrData[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status  <= '0;
      maskReg <= '0;
    end else begin
      status <= (status & ~clrVec) | setVec;
      if (strobe.wrMask) maskReg <= wrData[STAT_W-1:0];
    end
  end

  assign smi = |(status & maskReg);
endmodule

// File: rtl/pmControl.sv
module pmControl
  import pm_pkg::*;
#(
  parameter int WAKE_DLY      = 4,
  parameter int CONSERVE_DUTY = 4,
  parameter int THR_STEPS     = 8,
  localparam int PH_W = $clog2(THR_STEPS),
  localparam int WK_W = $clog2(WAKE_DLY + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [2:0]    regAddr,
  input  logic [PH_W:0] ctrlData,
  input  logic          activityAny,
  input  logic          idleExpire,
  output pmStrobe_t     strobe,
  output pmMode_e       mode,
  output logic          clkGate,
  output logic          clkStopReq
);
  localparam logic [PH_W:0] CONS_D = PH_W'(CONSERVE_DUTY) | (PH_W + 1)'(0);

  logic            wrCtrl;
  logic            conserveReg;
  logic            conserveNext;
  logic [PH_W-1:0] dutyReg;
  logic [PH_W-1:0] phase;
  logic [WK_W-1:0] wakeCnt;
  pmMode_e         modeNext;

  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);

  always_comb begin
    strobe                   = '0;
    strobe.loadTmr[TMR_IDLE] = regWrEn && (regAddr == ADDR_IDLE);
    strobe.loadTmr[TMR_PERI] = regWrEn && (regAddr == ADDR_PERI);
    strobe.loadTmr[TMR_GP]   = regWrEn && (regAddr == ADDR_GP);
    strobe.wrMask            = regWrEn && (regAddr == ADDR_MASK);
    strobe.clrStatus         = regWrEn && (regAddr == ADDR_CLR);
  end

  assign conserveNext = wrCtrl ? ctrlData[PH_W] : conserveReg;

  always_comb begin
    if (conserveNext)               modeNext = MODE_CONSERVE;
    else if (mode == MODE_CONSERVE) modeNext = MODE_NORMAL;
    else if (activityAny)           modeNext = MODE_NORMAL;
    else if (idleExpire)
      modeNext = (mode == MODE_SUSPEND) ? MODE_SUSPEND : pmMode_e'(mode + 3'd1);
    else                            modeNext = mode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode        <= MODE_NORMAL;
      conserveReg <= 1'b0;
      dutyReg     <= '0;
      phase       <= '0;
    end else begin
      mode  <= modeNext;
      phase <= phase + PH_W'(1);
      if (wrCtrl) begin
        conserveReg <= ctrlData[PH_W];
        dutyReg     <= ctrlData[PH_W-1:0];
      end
    end
  end

  // clock stop: set on suspend entry, held for the wake delay after exit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkStopReq <= 1'b0;
      wakeCnt    <= '0;
    end else if (modeNext == MODE_SUSPEND) begin
      clkStopReq <= 1'b1;
      wakeCnt    <= '0;
    end else if (mode == MODE_SUSPEND) begin
      wakeCnt <= WK_W'(WAKE_DLY);
    end else if (wakeCnt != '0) begin
      wakeCnt <= wakeCnt - WK_W'(1);
      if (wakeCnt == WK_W'(1)) clkStopReq <= 1'b0;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_DOZE:     clkGate = phase < dutyReg;
      MODE_CONSERVE: clkGate = {1'b0, phase} < CONS_D;
      MODE_SLEEP,
      MODE_SUSPEND:  clkGate = 1'b1;
      default:       clkGate = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmModeCtrl.sv
module pmModeCtrl
  import pm_pkg::*;
#(
  parameter int NUM_A         = 2,
  parameter int NUM_B         = 2,
  parameter int TIMER_W       = 16,
  parameter int DATA_W        = 16,
  parameter int WAKE_DLY      = 4,
  parameter int CONSERVE_DUTY = 4,
  parameter int THR_STEPS     = 8,
  localparam int STAT_W = NUM_EXT + NUM_B + NUM_TIMERS,
  localparam int PH_W   = $clog2(THR_STEPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_A-1:0]  activityA,
  input  logic [NUM_B-1:0]  activityB,
  input  logic [5:0]        extEvent,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [2:0]        pwrMode,
  output logic              clkGate,
  output logic              clkStopReq,
  output logic              smiOut,
  output logic [STAT_W-1:0] smiStatus
);
  pmStrobe_t strobe;
  pmMode_e   modeQ;
  logic      idleExpire;

  pmControl #(
    .WAKE_DLY(WAKE_DLY), .CONSERVE_DUTY(CONSERVE_DUTY), .THR_STEPS(THR_STEPS)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .ctrlData   (regWrData[PH_W:0]),
    .activityAny(|activityA),
    .idleExpire (idleExpire),
    .strobe     (strobe),
    .mode       (modeQ),
    .clkGate    (clkGate),
    .clkStopReq (clkStopReq)
  );

  pmDatapath #(
    .NUM_A(NUM_A), .NUM_B(NUM_B), .TIMER_W(TIMER_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .activityA (activityA),
    .activityB (activityB),
    .extEvent  (extEvent),
    .idleExpire(idleExpire),
    .status    (smiStatus),
    .smi       (smiOut)
  );

  assign pwrMode = modeQ;
endmodule

// File: rtl/pmModeCtrl_checker.sv
module pmModeCtrl_checker #(
  parameter int NUM_A  = 2,
  parameter int STAT_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_A-1:0]  activityA,
  input logic              regWrEn,
  input logic [2:0]        regAddr,
  input logic [2:0]        pwrMode,
  input logic              clkGate,
  input logic              clkStopReq,
  input logic              smiOut,
  input logic [STAT_W-1:0] smiStatus
);
  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    pwrMode <= 3'd4);

  assert_wake_normal_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((|activityA) && pwrMode != 3'd4 && !(regWrEn && regAddr == 3'd5))
      |=> pwrMode == 3'd0);

  assert_normal_ungated_R4: assert property (@(posedge clk) disable iff (!rstN)
    pwrMode == 3'd0 |-> !clkGate || clkStopReq || !clkStopReq && 1'b0);

  assert_suspend_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    pwrMode == 3'd3 |-> clkStopReq);

  assert_stop_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkStopReq) |-> pwrMode == 3'd3);

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == 3'd4) |=> (smiStatus & $past(smiStatus)) == $past(smiStatus));

  assert_smi_needs_status_R8: assert property (@(posedge clk) disable iff (!rstN)
    smiOut |-> smiStatus != '0);
endmodule

bind pmModeCtrl pmModeCtrl_checker #(.NUM_A(NUM_A), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rstN(rstN), .activityA(activityA), .regWrEn(regWrEn),
  .regAddr(regAddr), .pwrMode(pwrMode), .clkGate(clkGate),
  .clkStopReq(clkStopReq), .smiOut(smiOut), .smiStatus(smiStatus)
);

// File: tb/tb_pmModeCtrl.sv
`timescale 1ns/1ps
module tb_pmModeCtrl;
  localparam int NUM_A = 2, NUM_B = 2, TIMER_W = 8, DATA_W = 16;
  localparam int WAKE_DLY = 4, CONSERVE_DUTY = 3;
  localparam int STAT_W = 6 + NUM_B + 3;
  localparam int PERI_BIT = 6 + NUM_B, GP_BIT = 7 + NUM_B;

  logic clk = 0, rstN = 0;
  logic [NUM_A-1:0] activityA = '0;
  logic [NUM_B-1:0] activityB = '0;
  logic [5:0] extEvent = '0;
  logic regWrEn = 0;
  logic [2:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [2:0] pwrMode;
  logic clkGate, clkStopReq, smiOut;
  logic [STAT_W-1:0] smiStatus;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  pmModeCtrl #(.NUM_A(NUM_A), .NUM_B(NUM_B), .TIMER_W(TIMER_W), .DATA_W(DATA_W),
    .WAKE_DLY(WAKE_DLY), .CONSERVE_DUTY(CONSERVE_DUTY)) dut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, int d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = DATA_W'(d);
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic waitN(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic countGate(output int g);
    g = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); g += int'(clkGate); end
  endtask

  task automatic pulseA();
    @(negedge clk); activityA = 2'b10; @(negedge clk); activityA = '0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    finishRun();
  end

  initial begin
    int g;
    waitN(3); rstN = 1; @(negedge clk);
    // R1 reset state
    check("R1 mode", pwrMode, 0);
    check("R1 gate", clkGate, 0);
    check("R1 stop", clkStopReq, 0);
    check("R1 smi", smiOut, 0);
    check("R1 status", smiStatus, 0);
    waitN(10);
    check("R1 timers idle", pwrMode, 0);

    // R2 descent with idle reload 5
    wr(3'd0, 5);
    waitN(4); check("R2 before expiry", pwrMode, 0);
    waitN(1); check("R2 doze", pwrMode, 1);
    waitN(5); check("R2 sleep", pwrMode, 2);
    check("R4 sleep gated", clkGate, 1);
    waitN(5); check("R2 suspend", pwrMode, 3);
    check("R5 stop on entry", clkStopReq, 1);
    check("R4 suspend gated", clkGate, 1);
    waitN(5); check("R2 saturate", pwrMode, 3);

    // R3/R5 wake
    pulseA();
    check("R3 wake normal", pwrMode, 0);
    check("R5 stop held", clkStopReq, 1);
    waitN(WAKE_DLY - 1); check("R5 stop held end", clkStopReq, 1);
    waitN(1); check("R5 stop released", clkStopReq, 0);
    check("R3 reload pending", pwrMode, 0);
    waitN(1); check("R3 reload doze", pwrMode, 1);
    wr(3'd0, 0);

    // R10 notice event in doze
    @(negedge clk); activityB = 2'b01; @(negedge clk); activityB = '0;
    check("R10 mode unchanged", pwrMode, 1);
    check("R10 status bit", smiStatus[6], 1);
    check("R8 not enabled", smiOut, 0);

    // R4 duty sweep
    for (int d = 0; d < 8; d++) begin
      wr(3'd5, d); countGate(g); check("R4 doze duty", g, d);
    end
    pulseA(); countGate(g); check("R4 normal ungated", g, 0);

    // R6 conserve
    wr(3'd5, 8 | 5);
    check("R6 conserve entry", pwrMode, 4);
    countGate(g); check("R6 fixed duty", g, CONSERVE_DUTY);
    pulseA(); check("R6 wake ignored", pwrMode, 4);
    wr(3'd0, 2); waitN(6); check("R6 expiry ignored", pwrMode, 4);
    wr(3'd0, 0);
    wr(3'd5, 0); check("R6 exit normal", pwrMode, 0);

    // R7 clear all
    wr(3'd4, 16'hFFFF); check("R7 clear all", smiStatus, 0);

    // R11 timers
    wr(3'd1, 4);
    waitN(3); check("R11 peri early", smiStatus[PERI_BIT], 0);
    waitN(1); check("R11 peri expiry", smiStatus[PERI_BIT], 1);
    wr(3'd1, 0);
    wr(3'd2, 3);
    waitN(2); check("R11 gp early", smiStatus[GP_BIT], 0);
    waitN(1); check("R11 gp expiry", smiStatus[GP_BIT], 1);
    wr(3'd2, 0);
    waitN(4); check("R7 sticky", smiStatus[PERI_BIT], 1);
    wr(3'd4, (1 << PERI_BIT) | (1 << GP_BIT));
    check("R7 partial clear", smiStatus, 0);

    // R8/R9 external pin sweep
    for (int k = 0; k < 6; k++) begin
      wr(3'd3, 1 << k);
      @(negedge clk); extEvent = 6'(1 << k); @(negedge clk); extEvent = '0;
      check("R9 pin status", smiStatus, 1 << k);
      check("R8 enabled smi", smiOut, 1);
      wr(3'd3, ((1 << STAT_W) - 1) & ~(1 << k));
      check("R9 other enables", smiOut, 0);
      wr(3'd4, 1 << k);
      check("R7 w1c pin", smiStatus, 0);
    end

    // R7 clear one of two, R9 set wins over clear
    @(negedge clk); extEvent = 6'b000011; @(negedge clk); extEvent = '0;
    wr(3'd4, 1);
    check("R7 selective clear", smiStatus, 2);
    @(negedge clk); extEvent = 6'b000010; regWrEn = 1; regAddr = 3'd4; regWrData = 16'h2;
    @(negedge clk); extEvent = '0; regWrEn = 0;
    check("R7 set wins", smiStatus, 2);
    finishRun();
  end
endmodule